// File: doc/BRIEF.md
# Disparity Error Back-Marker for Decoded Lane Codes

This block sits on one lane, directly behind an 8b/10b decoder. Each clock it takes one decoded code: an 8-bit value, a flag that marks it as a control code, a flag for a running-disparity error, and a valid strobe. It returns the same stream after a fixed delay. A disparity error can enter inside a run of data codes and stay hidden until a control code with a strict disparity pattern shows it. The block handles this case by holding recent codes in a short delay line.

Three control codes act as detectors: K28.3 (0x7C), K28.5 (0xBC) and K29.7 (0xFD). When one of them arrives valid and carries a disparity error, every valid data code still in the delay line is rewritten as the control code 0xFE. The protocol logic downstream then sees an error inside the packet and drops it. The detecting code itself leaves the line unchanged and keeps its error flag.

Top module: `eop_err_marker`

## Requirements
- R1: Each code appears on the outputs exactly DEPTH clock cycles (default 8) after it is sampled, and outValid follows inValid with that same latency.
- R2: If no trigger occurs while a code is in the line, its value, control flag and disparity-error flag leave unchanged.
- R3: A trigger is a code that is valid, has the control flag set, has the disparity-error flag set and has value 0x7C, 0xBC or 0xFD. On a trigger, every valid data code (control flag 0) among the DEPTH-1 codes sampled just before it leaves with value 0xFE and the control flag set. Its disparity-error flag is not changed.
- R4: The trigger code itself leaves with its own value, the control flag set and the disparity-error flag set.
- R5: Control codes in the line are never altered by a trigger.
- R6: None of the following causes a trigger: a disparity error on a data code, a disparity error on any other control value (for example 0xFB), the value 0xBC arriving as data, or a trigger pattern with inValid low. Each of these codes passes through unchanged.
- R7: A trigger does not alter codes sampled DEPTH or more cycles before it (these have already left the line) or any code sampled after it.
- R8: Reset is asynchronous and active low. It clears every valid bit in the line, so outValid is 0 during reset and for DEPTH cycles after reset is released, until new input reaches the output.
- R9: An empty slot (inValid low) leaves as an empty slot, including when a trigger passes over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input code is valid |
| inData | input | 8 | Decoded code value |
| inCtrl | input | 1 | Input code is a control code |
| inDispErr | input | 1 | Running-disparity error on the input code |
| outValid | output | 1 | Output code is valid |
| outData | output | 8 | Delayed code value, 0xFE if back-marked |
| outCtrl | output | 1 | Output code is a control code |
| outDispErr | output | 1 | Disparity-error flag of the output code |

## Verification
The bench targets the boundary of the marking window. The code sampled DEPTH cycles before a trigger must stay intact while the one sampled DEPTH-1 cycles before must be marked, so a design that is off by one either corrupts a packet that has already left or lets one bad data code through. It sends near-miss triggers: an error on /S/, 0xBC sent as data, and an error on a data code. A decoder that ignores the control flag or the value would then poison good packets. The bench also places a control code and empty slots inside the window, where a careless rewrite would clobber the control code or turn a gap into a false 0xFE. It sends a second trigger over entries that are already marked, and it resets the block while data is in flight. After that reset the first trigger has fewer than DEPTH-1 predecessors.

// File: rtl/eop_mark_pkg.sv
package eop_mark_pkg;

  localparam int CODE_W   = 8;
  localparam int NUM_TRIG = 3;

  localparam logic [CODE_W-1:0] ERR_CODE   = 8'hFE;
  localparam logic [CODE_W-1:0] CODE_ALIGN = 8'h7C;  // K28.3
  localparam logic [CODE_W-1:0] CODE_IDLE  = 8'hBC;  // K28.5
  localparam logic [CODE_W-1:0] CODE_TERM  = 8'hFD;  // K29.7

  typedef struct packed {
    logic              valid;
    logic              ctrl;
    logic              dispErr;
    logic [CODE_W-1:0] data;
  } slot_t;

  typedef struct packed {
    logic load;   // capture a new code into the first stage
    logic mark;   // poison buffered data codes on this shift
  } strobe_t;

endpackage

// File: rtl/eop_mark_ctrl.sv
module eop_mark_ctrl
  import eop_mark_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inCtrl,
  input  logic              inDispErr,
  input  logic [CODE_W-1:0] inData,
  output strobe_t           strb
);

  localparam logic [CODE_W-1:0] TRIG_CODES [NUM_TRIG] = '{CODE_ALIGN, CODE_IDLE, CODE_TERM};

  logic [NUM_TRIG-1:0] codeHit;

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_match
    assign codeHit[t] = (inData == TRIG_CODES[t]);
  end

  logic isDetector;
  assign isDetector = inValid && inCtrl && (|codeHit);

  always_comb begin
    strb      = '0;
    strb.load = inValid;
    strb.mark = isDetector && inDispErr;
  end

  // R6
  no_err_no_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inDispErr |-> !strb.mark);

  // R6
  data_no_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inCtrl |-> !strb.mark);

  // R3
  term_err_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inCtrl && inDispErr && inData == CODE_TERM) |-> strb.mark);

endmodule

// File: rtl/eop_mark_dp.sv
module eop_mark_dp
  import eop_mark_pkg::*;
#(
  parameter int DEPTH = 8
)(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t strb,
  input  slot_t   inSlot,
  output slot_t   outSlot
);

  localparam int LAST = DEPTH - 1;

  slot_t line [DEPTH];

  function automatic slot_t poison(slot_t s);
    slot_t r;
    r = s;
    if (s.valid && !s.ctrl) begin
      r.data = ERR_CODE;
      r.ctrl = 1'b1;
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) line[i] <= '0;
    end else begin
      line[0].valid <= strb.load;
      if (strb.load) begin
        line[0].ctrl    <= inSlot.ctrl;
        line[0].dispErr <= inSlot.dispErr;
        line[0].data    <= inSlot.data;
      end
      for (int i = 1; i < DEPTH; i++)
        line[i] <= strb.mark ? poison(line[i-1]) : line[i-1];
    end
  end

  assign outSlot = line[LAST];

  // R4
  entry_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.load) |-> (line[0].valid && line[0].ctrl == $past(inSlot.ctrl)
      && line[0].dispErr == $past(inSlot.dispErr) && line[0].data == $past(inSlot.data)));

  // R8
  reset_empty_chk: assert property (@(posedge clk)
    !rstN |=> !outSlot.valid);

  for (genvar i = 1; i < DEPTH; i++) begin : g_chk
    // R3
    mark_data_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strb.mark) && $past(line[i-1].valid) && !$past(line[i-1].ctrl))
        |-> (line[i].data == ERR_CODE && line[i].ctrl && line[i].valid));

    // R5
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(line[i-1].ctrl) |-> (line[i] == $past(line[i-1])));

    // R9
    empty_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(line[i-1].valid) |-> !line[i].valid);

    // R2
    pass_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strb.mark) |-> (line[i] == $past(line[i-1])));
  end

endmodule

// File: rtl/eop_err_marker.sv
module eop_err_marker
  import eop_mark_pkg::*;
#(
  parameter int DEPTH = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inData,
  input  logic              inCtrl,
  input  logic              inDispErr,
  output logic              outValid,
  output logic [CODE_W-1:0] outData,
  output logic              outCtrl,
  output logic              outDispErr
);

  strobe_t strb;
  slot_t   inSlot;
  slot_t   outSlot;

  assign inSlot.valid   = inValid;
  assign inSlot.ctrl    = inCtrl;
  assign inSlot.dispErr = inDispErr;
  assign inSlot.data    = inData;

  eop_mark_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inCtrl    (inCtrl),
    .inDispErr (inDispErr),
    .inData    (inData),
    .strb      (strb)
  );

  eop_mark_dp #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inSlot  (inSlot),
    .outSlot (outSlot)
  );

  assign outValid   = outSlot.valid;
  assign outData    = outSlot.data;
  assign outCtrl    = outSlot.ctrl;
  assign outDispErr = outSlot.dispErr;

endmodule

// File: tb/eop_err_marker_test.sv
module eop_err_marker_test;

  localparam int DEPTH = 8;
  localparam int HMAX  = 512;
  localparam int NVEC  = 33;

  // row: {req tag[3:0], valid, ctrl, dispErr, data[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd1, 3'b110, 8'hBC}, {4'd5, 3'b110, 8'hFB}, {4'd3, 3'b100, 8'h11}, {4'd3, 3'b100, 8'h12},
    {4'd3, 3'b100, 8'h13}, {4'd3, 3'b100, 8'h14}, {4'd3, 3'b100, 8'h15}, {4'd3, 3'b101, 8'h16},
    {4'd4, 3'b111, 8'hFD}, {4'd7, 3'b100, 8'h21}, {4'd6, 3'b101, 8'h22}, {4'd6, 3'b111, 8'hFB},
    {4'd6, 3'b011, 8'hBC}, {4'd6, 3'b011, 8'hFD}, {4'd2, 3'b100, 8'h23}, {4'd2, 3'b100, 8'h24},
    {4'd2, 3'b110, 8'h1C}, {4'd2, 3'b100, 8'h25}, {4'd7, 3'b100, 8'h31}, {4'd7, 3'b100, 8'h32},
    {4'd9, 3'b000, 8'h00}, {4'd3, 3'b100, 8'h33}, {4'd9, 3'b000, 8'h00}, {4'd3, 3'b100, 8'h34},
    {4'd5, 3'b110, 8'hBC}, {4'd3, 3'b100, 8'h35}, {4'd3, 3'b100, 8'h36}, {4'd4, 3'b111, 8'h7C},
    {4'd3, 3'b100, 8'h41}, {4'd4, 3'b111, 8'hBC}, {4'd7, 3'b100, 8'h42}, {4'd2, 3'b100, 8'h43},
    {4'd2, 3'b110, 8'hBC}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inCtrl = 1'b0;
  logic       inDispErr = 1'b0;
  logic       outValid;
  logic [7:0] outData;
  logic       outCtrl;
  logic       outDispErr;

  int total = 0;
  int bad = 0;
  int idx = 0;
  bit finished = 1'b0;

  logic       expV [HMAX];
  logic       expC [HMAX];
  logic       expE [HMAX];
  logic [7:0] expD [HMAX];
  int         expR [HMAX];

  always #5 clk = ~clk;

  eop_err_marker #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData), .inCtrl(inCtrl),
    .inDispErr(inDispErr), .outValid(outValid), .outData(outData), .outCtrl(outCtrl),
    .outDispErr(outDispErr)
  );

  function automatic string reqName(int r);
    case (r)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  // compare outputs against the model entry sampled DEPTH drives earlier
  task automatic checkEntry(int j);
    bit ok;
    total++;
    if (j < 0 || !expV[j]) begin
      ok = !outValid;
      if (!ok) begin
        bad++;
        $display("FAIL %s: slot %0d outValid=%0b expected 0",
                 (j < 0) ? "R8" : reqName(expR[j]), j, outValid);
      end
    end else begin
      ok = outValid && outCtrl == expC[j] && outDispErr == expE[j] && outData == expD[j];
      if (!ok) begin
        bad++;
        $display("FAIL %s: slot %0d got v=%0b c=%0b e=%0b d=%02h expected v=1 c=%0b e=%0b d=%02h",
                 reqName(expR[j]), j, outValid, outCtrl, outDispErr, outData,
                 expC[j], expE[j], expD[j]);
      end
    end
  endtask

  task automatic drive(logic v, logic c, logic e, logic [7:0] d, int r);
    @(negedge clk);
    checkEntry(idx - DEPTH);
    expV[idx] = v; expC[idx] = c; expE[idx] = e; expD[idx] = d; expR[idx] = r;
    if (v && c && e && (d == 8'h7C || d == 8'hBC || d == 8'hFD)) begin
      for (int k = 1; k < DEPTH; k++) begin
        if (idx - k >= 0 && expV[idx-k] && !expC[idx-k]) begin
          expD[idx-k] = 8'hFE;
          expC[idx-k] = 1'b1;
          expR[idx-k] = 3;
        end
      end
    end
    inValid = v; inCtrl = c; inDispErr = e; inData = d;
    idx++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0; inCtrl = 1'b0; inDispErr = 1'b0; inData = '0;
    repeat (3) @(negedge clk);
    total++;
    if (outValid !== 1'b0 || outData !== 8'h00) begin
      bad++;
      $display("FAIL R8: during reset outValid=%0b outData=%02h expected 0/00", outValid, outData);
    end
    for (int k = 1; k <= DEPTH; k++)
      if (idx - k >= 0) expV[idx-k] = 1'b0;
    rstN = 1'b1;
    expV[idx] = 1'b0; expC[idx] = 1'b0; expE[idx] = 1'b0; expD[idx] = '0; expR[idx] = 8;
    idx++;
  endtask

  initial begin
    for (int i = 0; i < HMAX; i++) begin
      expV[i] = 1'b0; expC[i] = 1'b0; expE[i] = 1'b0; expD[i] = '0; expR[i] = 1;
    end
    doReset();
    // table walk: R1..R7, R9
    for (int i = 0; i < NVEC; i++)
      drive(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7:0], int'(VEC[i][14:11]));
    for (int i = 0; i < DEPTH; i++) drive(1'b1, 1'b1, 1'b0, 8'hBC, 1);
    // R8: reset with data in flight, then short-history trigger (R3, R4)
    drive(1'b1, 1'b0, 1'b0, 8'h51, 8);
    drive(1'b1, 1'b0, 1'b0, 8'h52, 8);
    drive(1'b1, 1'b0, 1'b0, 8'h53, 8);
    doReset();
    drive(1'b1, 1'b0, 1'b0, 8'h61, 3);
    drive(1'b1, 1'b0, 1'b1, 8'h62, 3);
    drive(1'b1, 1'b1, 1'b1, 8'hFD, 4);
    for (int i = 0; i < DEPTH + 1; i++) drive(1'b0, 1'b0, 1'b0, 8'h00, 9);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1: watchdog expired, got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule